// File: doc/BRIEF.md
# Timebase Capture/Compare Cell Group

This block is a group of 24-bit timer cells that share two free-running timebase buses. Each cell is set up on its own as a capture cell or as a compare cell. A capture cell records the value of the timebase it has chosen when a chosen edge appears on its input pin. A compare cell watches its chosen timebase. When that timebase reaches the cell's stored value, the cell drives a registered output pin high, drives it low, toggles it, or leaves it as it is.

A cell can be linked to the cell below it. A linked cell then works on the pin of that lower cell instead of its own pin. Links can be chained, so several cells can place edges on one output pin to build a multi-edge waveform, or record several points of one input signal. Each cell keeps a sticky event flag that software clears through the register port.

All registers sit behind one simple write port and one read port. The read port has one cycle of latency. The address is `{cell index, register select}`, where the register select is the two low address bits.

Top module: `tbcc_group`

## Requirements
- R1: After a synchronous reset, every output pin is 0, every event flag is 0, every value register is 0 and every control register is 0. A control register of 0 means capture mode with no trigger edge.
- R2: A write with register select 0 loads the cell value register. Select 1 loads the control register from data bits [6:0]. Reading with select 0 returns the value and select 1 returns the control register zero-extended. `rd_data_o` shows the register addressed in the previous cycle.
- R3: In capture mode, control bit 1 picks the timebase (0 = `tb0_i`, 1 = `tb1_i`). Each input pin passes through two synchronising flip-flops and an edge detector. A capture loads the timebase value present at the third rising clock edge after the pin changes. A capture in the same cycle as a value write wins over the write.
- R4: Control bits [3:2] set the capture trigger: 01 = rising edge, 10 = falling edge, 11 = both edges, 00 = never. Edges that are not selected leave the value register unchanged.
- R5: In compare mode (control bit 0 = 1), a match occurs when the selected timebase equals the value register. On a match, the target output pin is updated at that clock edge according to control bits [5:4]: 00 = no change, 01 = set, 10 = clear, 11 = toggle.
- R6: A match is acted on once for each arrival of the timebase at the value. A timebase that stays equal for several cycles causes one action. Leaving the value and coming back causes a new action.
- R7: When control bit 6 (link) is set on cell k > 0, cell k uses the pin of cell k-1, and that pin may itself be inherited through a chain of links. Cell k then captures from that input pin and drives that output pin, and its own output pin stays unchanged. The link bit has no effect on cell 0.
- R8: When several cells act on the same output pin in the same cycle, the action of the highest-index cell wins. A "no change" action overrides nothing.
- R9: A cell's event flag (`evt_o[k]`) is set by a capture or by a compare match and stays set. A write with register select 2 and data bit 0 = 1 clears it. If a set and a clear happen in the same cycle, the set wins. Reading with select 2 returns the flag in bit 0.
- R10: A cell in capture mode never changes an output pin. A cell in compare mode never captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb0_i | input | TW | Shared timebase 0 |
| tb1_i | input | TW | Shared timebase 1 |
| pin_i | input | NCELL | Asynchronous input pin per cell |
| pin_o | output | NCELL | Registered output pin per cell |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Write address {cell, select} |
| wr_data_i | input | TW | Write data |
| rd_addr_i | input | AW | Read address {cell, select} |
| rd_data_o | output | TW | Registered read data, one cycle after address |
| evt_o | output | NCELL | Sticky event flag per cell |

## Verification
The assertions assume the timebases and register writes are synchronous to `clk`. They also assume that no value write falls in the cycle where a capture is loaded, since the capture overrides the write. The stimulus changes the timebases and the pins only on the falling clock edge. It holds the timebases still while capture results are read back, and it never schedules a value write close to a pin edge. Pins are toggled only after the previous edge has had time to pass through the synchroniser. The bench compares the outputs and the read data against its behavioural model on every cycle.

// File: rtl/tbcc_pkg.sv
package tbcc_pkg;
  localparam int CTL_W = 7;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // bit6 link, bits5:4 action, bits3:2 edge mask, bit1 timebase, bit0 compare
  typedef struct packed {
    logic       link;
    act_e       act;
    logic [1:0] edg;
    logic       tbsel;
    logic       cmp;
  } ctl_t;
endpackage

// File: rtl/tbcc_insync.sv
module tbcc_insync #(
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] pin_i,
  output logic [NP-1:0] rise_o,
  output logic [NP-1:0] fall_o
);
  logic [NP-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/tbcc_cell.sv
module tbcc_cell
  import tbcc_pkg::*;
#(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tb0_i,
  input  logic [TW-1:0] tb1_i,
  input  logic          wr_val_i,
  input  logic          wr_ctl_i,
  input  logic          wr_clr_i,
  input  logic [TW-1:0] wr_data_i,
  input  logic          rise_i,
  input  logic          fall_i,
  output logic [TW-1:0] val_o,
  output ctl_t          ctl_o,
  output logic          flag_o,
  output logic          hit_o
);
  ctl_t          ctl_q;
  logic [TW-1:0] val_q;
  logic [TW-1:0] tb_sel;
  logic          eq, eq_q, cap, flag_q;

  assign tb_sel = ctl_q.tbsel ? tb1_i : tb0_i;
  assign eq     = (tb_sel == val_q);
  assign cap    = !ctl_q.cmp && ((ctl_q.edg[0] && rise_i) || (ctl_q.edg[1] && fall_i));
  assign hit_o  = ctl_q.cmp && eq && !eq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      val_q  <= '0;
      eq_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      eq_q <= eq;
      if (cap)           val_q <= tb_sel;
      else if (wr_val_i) val_q <= wr_data_i;
      if (wr_ctl_i)      ctl_q <= ctl_t'(wr_data_i[CTL_W-1:0]);
      flag_q <= (flag_q & ~wr_clr_i) | cap | hit_o;
    end
  end

  assign val_o  = val_q;
  assign ctl_o  = ctl_q;
  assign flag_o = flag_q;

  // R3
  cap_val_chk: assert property (@(posedge clk) disable iff (rst)
    cap |=> (val_q == $past(tb_sel)));

  // R4
  val_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rise_i && !fall_i && !wr_val_i) |=> $stable(val_q));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !wr_clr_i) |=> flag_q);
endmodule

// File: rtl/tbcc_pinmux.sv
module tbcc_pinmux
  import tbcc_pkg::*;
#(
  parameter int NCELL = 4,
  parameter int SW    = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCELL-1:0]      hit_i,
  input  logic [2*NCELL-1:0]    act_i,
  input  logic [SW*NCELL-1:0]   src_i,
  output logic [NCELL-1:0]      pin_o
);
  logic [NCELL-1:0] pin_q, pin_d;

  always_comb begin
    pin_d = pin_q;
    for (int p = 0; p < NCELL; p++) begin
      for (int k = 0; k < NCELL; k++) begin
        if (hit_i[k] && (src_i[k*SW +: SW] == SW'(p))) begin
          case (act_e'(act_i[2*k +: 2]))
            ACT_SET: pin_d[p] = 1'b1;
            ACT_CLR: pin_d[p] = 1'b0;
            ACT_TGL: pin_d[p] = ~pin_q[p];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_d;
  end

  assign pin_o = pin_q;

  // R10
  pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_i == '0) |=> $stable(pin_q));
endmodule

// File: rtl/tbcc_group.sv
module tbcc_group
  import tbcc_pkg::*;
#(
  parameter int NCELL = 4,
  parameter int TW    = 24,
  localparam int CIW  = (NCELL > 1) ? $clog2(NCELL) : 1,
  localparam int AW   = CIW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TW-1:0]    tb0_i,
  input  logic [TW-1:0]    tb1_i,
  input  logic [NCELL-1:0] pin_i,
  output logic [NCELL-1:0] pin_o,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [TW-1:0]    wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [TW-1:0]    rd_data_o,
  output logic [NCELL-1:0] evt_o
);
  logic [NCELL-1:0]     rise, fall, hit, flag;
  logic [TW-1:0]        val_v [NCELL];
  ctl_t                 ctl_v [NCELL];
  logic [CIW-1:0]       src   [NCELL];
  logic [CIW*NCELL-1:0] src_flat;
  logic [2*NCELL-1:0]   act_flat;
  logic [TW-1:0]        rd_q;

  tbcc_insync #(.NP(NCELL)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  // resolve link chains: each cell inherits the pin of the nearest unlinked cell below
  always_comb begin
    logic [CIW-1:0] cur;
    cur = '0;
    for (int k = 0; k < NCELL; k++) begin
      if (k == 0 || !ctl_v[k].link) cur = CIW'(k);
      src[k] = cur;
    end
  end

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    logic sel_k;
    assign sel_k = wr_en_i && (wr_addr_i[AW-1:2] == CIW'(k));
    assign src_flat[k*CIW +: CIW] = src[k];
    assign act_flat[2*k +: 2]     = ctl_v[k].act;

    tbcc_cell #(.TW(TW)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .tb0_i    (tb0_i),
      .tb1_i    (tb1_i),
      .wr_val_i (sel_k && wr_addr_i[1:0] == 2'd0),
      .wr_ctl_i (sel_k && wr_addr_i[1:0] == 2'd1),
      .wr_clr_i (sel_k && wr_addr_i[1:0] == 2'd2 && wr_data_i[0]),
      .wr_data_i(wr_data_i),
      .rise_i   (rise[src[k]]),
      .fall_i   (fall[src[k]]),
      .val_o    (val_v[k]),
      .ctl_o    (ctl_v[k]),
      .flag_o   (flag[k]),
      .hit_o    (hit[k])
    );
  end

  tbcc_pinmux #(.NCELL(NCELL), .SW(CIW)) u_pins (
    .clk(clk), .rst(rst), .hit_i(hit), .act_i(act_flat), .src_i(src_flat), .pin_o(pin_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (rd_addr_i[1:0])
        2'd0:    rd_q <= val_v[rd_addr_i[AW-1:2]];
        2'd1:    rd_q <= {{(TW-CTL_W){1'b0}}, ctl_v[rd_addr_i[AW-1:2]]};
        2'd2:    rd_q <= {{(TW-1){1'b0}}, flag[rd_addr_i[AW-1:2]]};
        default: rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o = rd_q;
  assign evt_o     = flag;

  // R9
  evt_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_o[0]) |-> ($past(hit[0]) || $past(ctl_v[0].cmp) == 1'b0));
endmodule

// File: tb/tb_tbcc_group.sv
`timescale 1ns/1ps
module tb_tbcc_group;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] tb0 = '0, tb1 = '0;
  logic [3:0]  pin_in = '0;
  logic [3:0]  pin_out, evt;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [23:0] wr_data = '0, rd_data;

  int    n_run = 0, n_fail = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  tbcc_group dut (
    .clk(clk), .rst(rst), .tb0_i(tb0), .tb1_i(tb1), .pin_i(pin_in), .pin_o(pin_out),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .evt_o(evt)
  );

  // behavioural reference model
  logic [23:0] m_val [4];
  logic [6:0]  m_ctl [4];
  logic [3:0]  m_flag, m_pin, m_eqq, q1, q2, q3, mr, mf, mcap, mhit, meq, npin;
  logic [23:0] m_rd;
  logic [23:0] mtbs [4];
  int          msrc [4];

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 4; k++) begin m_val[k] = '0; m_ctl[k] = '0; end
      m_flag = '0; m_pin = '0; m_eqq = '0; q1 = '0; q2 = '0; q3 = '0; m_rd = '0;
    end else begin
      mr = q2 & ~q3;
      mf = ~q2 & q3;
      for (int k = 0; k < 4; k++) begin
        msrc[k] = (k > 0 && m_ctl[k][6]) ? msrc[k-1] : k;
        mtbs[k] = m_ctl[k][1] ? tb1 : tb0;
        meq[k]  = (mtbs[k] == m_val[k]);
        mcap[k] = !m_ctl[k][0] && ((m_ctl[k][2] && mr[msrc[k]]) || (m_ctl[k][3] && mf[msrc[k]]));
        mhit[k] = m_ctl[k][0] && meq[k] && !m_eqq[k];
      end
      case (rd_addr[1:0])
        2'd0: m_rd = m_val[rd_addr[3:2]];
        2'd1: m_rd = {17'd0, m_ctl[rd_addr[3:2]]};
        2'd2: m_rd = {23'd0, m_flag[rd_addr[3:2]]};
        default: m_rd = '0;
      endcase
      npin = m_pin;
      for (int k = 0; k < 4; k++) begin
        if (mhit[k]) begin
          if (m_ctl[k][5:4] == 2'b01) npin[msrc[k]] = 1'b1;
          if (m_ctl[k][5:4] == 2'b10) npin[msrc[k]] = 1'b0;
          if (m_ctl[k][5:4] == 2'b11) npin[msrc[k]] = ~m_pin[msrc[k]];
        end
      end
      m_pin = npin;
      for (int k = 0; k < 4; k++) begin
        if (wr_en && wr_addr[1:0] == 2'd2 && wr_addr[3:2] == k && wr_data[0]) m_flag[k] = 1'b0;
        if (mcap[k] || mhit[k]) m_flag[k] = 1'b1;
        if (mcap[k]) m_val[k] = mtbs[k];
        else if (wr_en && wr_addr[1:0] == 2'd0 && wr_addr[3:2] == k) m_val[k] = wr_data;
        if (wr_en && wr_addr[1:0] == 2'd1 && wr_addr[3:2] == k) m_ctl[k] = wr_data[6:0];
      end
      m_eqq = meq;
      q3 = q2; q2 = q1; q1 = pin_in;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check({cur_req, " pins"}, {28'd0, pin_out}, {28'd0, m_pin});
      check({cur_req, " flags"}, {28'd0, evt}, {28'd0, m_flag});
      check({cur_req, " read"}, {8'd0, rd_data}, {8'd0, m_rd});
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [23:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rdchk(string req, logic [3:0] a, logic [23:0] exp);
    rd_addr = a;
    tick();
    check(req, {8'd0, rd_data}, {8'd0, exp});
  endtask

  task automatic sweep(int lo, int hi);
    for (int i = lo; i <= hi; i++) begin tb0 = 24'(i); tick(); end
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1", {28'd0, pin_out}, 32'd0);
    check("R1", {28'd0, evt}, 32'd0);
    rdchk("R1", 4'h0, 24'h0);
    rdchk("R1", 4'h1, 24'h0);

    cur_req = "R2";
    wr(4'h4, 24'h123456);
    rdchk("R2", 4'h4, 24'h123456);
    wr(4'h5, 24'h35);
    rdchk("R2", 4'h5, 24'h35);
    wr(4'h5, 24'h0);

    cur_req = "R3";
    wr(4'h1, 24'h06);             // capture, tb1, rising
    tb0 = 24'h111111; tb1 = 24'hABCDEF;
    pin_in[0] = 1'b1; tick(5);
    rdchk("R3", 4'h0, 24'hABCDEF);
    check("R9", {31'd0, evt[0]}, 32'd1);
    wr(4'h2, 24'h1);
    check("R9", {31'd0, evt[0]}, 32'd0);

    cur_req = "R4";
    tb1 = 24'h222222; pin_in[0] = 1'b0; tick(5);
    rdchk("R4", 4'h0, 24'hABCDEF);
    wr(4'h1, 24'h0A);             // falling only
    tb1 = 24'h333333; pin_in[0] = 1'b1; tick(5);
    rdchk("R4", 4'h0, 24'hABCDEF);
    pin_in[0] = 1'b0; tick(5);
    rdchk("R4", 4'h0, 24'h333333);
    wr(4'h1, 24'h0C);             // both edges, tb0
    tb0 = 24'h444444; pin_in[0] = 1'b1; tick(5);
    rdchk("R3", 4'h0, 24'h444444);
    wr(4'h1, 24'h00);             // no edge
    tb0 = 24'h454545; pin_in[0] = 1'b0; tick(5);
    rdchk("R4", 4'h0, 24'h444444);

    cur_req = "R5";
    tb0 = '0;
    wr(4'h8, 24'd100); wr(4'h9, 24'h11);
    sweep(90, 110);
    check("R5", {31'd0, pin_out[2]}, 32'd1);
    wr(4'h8, 24'd105); wr(4'h9, 24'h21);
    sweep(90, 110);
    check("R5", {31'd0, pin_out[2]}, 32'd0);

    cur_req = "R6";
    wr(4'h8, 24'd100); wr(4'h9, 24'h31);
    tb0 = 24'd100; tick(6);
    check("R6", {31'd0, pin_out[2]}, 32'd1);
    sweep(101, 101); sweep(100, 100); tick(3);
    check("R6", {31'd0, pin_out[2]}, 32'd0);

    cur_req = "R10";
    wr(4'h9, 24'h10);             // capture mode with an action code
    sweep(95, 105);
    check("R10", {28'd0, pin_out}, 32'd0);

    cur_req = "R7";
    tb0 = '0;
    wr(4'hC, 24'd50); wr(4'hD, 24'h51);
    wr(4'h8, 24'd60); wr(4'h9, 24'h21);
    sweep(40, 55);
    check("R7", {31'd0, pin_out[2]}, 32'd1);
    check("R7", {31'd0, pin_out[3]}, 32'd0);
    sweep(56, 70);
    check("R7", {31'd0, pin_out[2]}, 32'd0);
    wr(4'h5, 24'h44);             // cell1 linked capture, rising, tb0
    tb0 = 24'h555555; pin_in[1] = 1'b1; tick(5);
    rdchk("R7", 4'h4, 24'h123456);
    pin_in[0] = 1'b1; tick(5);
    rdchk("R7", 4'h4, 24'h555555);

    cur_req = "R8";
    tb0 = '0;
    wr(4'h8, 24'd80); wr(4'h9, 24'h11);
    wr(4'hC, 24'd80); wr(4'hD, 24'h61);
    sweep(75, 85);
    check("R8", {31'd0, pin_out[2]}, 32'd0);
    wr(4'h9, 24'h21); wr(4'hD, 24'h51);
    sweep(75, 85);
    check("R8", {31'd0, pin_out[2]}, 32'd1);

    cur_req = "R9";
    wr(4'h8, 24'd90); wr(4'h9, 24'h01);
    tb0 = 24'd89; tick(2);
    wr(4'hA, 24'h1);
    check("R9", {31'd0, evt[2]}, 32'd0);
    tb0 = 24'd90;
    wr(4'hA, 24'h1);              // match and clear in the same cycle
    check("R9", {31'd0, evt[2]}, 32'd1);
    wr(4'hA, 24'h1);
    check("R9", {31'd0, evt[2]}, 32'd0);
    rdchk("R9", 4'hA, 24'h0);
    tick(3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule